// File: doc/BRIEF.md
# Raster Line-and-Dot Interrupt Generator

This block raises a one-clock interrupt pulse when the display raster reaches a programmed line and dot position. A raster counter beside it supplies the current line, the dot position within that line, the field flag, the interlace flag, the total line count and the line length. One clock of this block equals one dot clock. Software sets the block up through a single 32-bit configuration write. The block has three repeat behaviours: a fixed line once per frame, every N half-frame lines, and every line.

The programmed line is given in half-frame units. A target t selects raster line 2t in the even field and line 2t+1 in the odd field. The field bit is only used when interlacing is on. In the repeating modes the target moves forward by N after each pulse. If the sum goes past half the total line count, half the total is subtracted from it until it no longer does. The firing dot is taken from the configuration in steps of two dots and is clamped to the last dot of the line.

Top module: `hpos_raster_irq`

## Requirements
- R1: After reset `irq` is low and `cfg_q` is zero. No pulse is produced before the first configuration write, whatever the raster inputs are.
- R2: A write stores `cfg_wdata & 32'h03FF33FF`. The stored value is visible on `cfg_q` in the cycle after the write.
- R3: Bit fields of the configuration word:
  - bits 9:0 hold the line field;
  - bits 13:12 hold the mode: 0 = once per frame, 1 = every N, 2 = every line, 3 = treated as 0;
  - bits 25:16 hold the dot field, whose value h selects dot 2h.
- R4: The firing dot is min(2h, `line_len`-1).
- R5: Target t matches raster line 2t+f, where f = `odd_field` when `interlaced` is 1 and f = 0 otherwise. A line at or above `total_lines` never fires, so a target whose mapped line is at or above `total_lines` never pulses.
- R6: In modes 0 and 3 the target equals the line field and never moves. The block pulses each time the raster reaches that line and dot.
- R7: A write in mode 1 sets N to the line field. The first target is wrap(floor(`line_num`/2) + N), where `line_num` is sampled in the write cycle. wrap(s) is s when s ≤ H, and ((s-1) mod H)+1 otherwise, where H = floor(`total_lines`/2).
- R8: After each pulse in mode 1 or mode 2, the target becomes wrap(target + N).
- R9: Mode 2 behaves as mode 1 with N forced to 1, whatever the line field holds.
- R10: `irq` is high in the cycle after the cycle whose inputs match. It stays high for exactly one cycle. It does not rise again until the match has gone away for at least one cycle.
- R11: A match in a write cycle is ignored, so `irq` is low in the cycle after any write. The new setting is compared from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| line_num | input | RAS_W | Current raster line |
| dot_pos | input | DOT_W | Current dot within the line |
| odd_field | input | 1 | 1 while the odd field is scanned |
| interlaced | input | 1 | 1 when the raster is interlaced |
| total_lines | input | RAS_W | Lines per frame |
| line_len | input | DOT_W | Dots per line |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_q | output | 32 | Stored, masked configuration |
| irq | output | 1 | Interrupt pulse |

## Verification
A configuration write can land in the same cycle as a line-and-dot match, and the write must win. The bench arms a fixed-line setting, then writes the same word while driving exactly the matching line and dot. It expects `irq` low in the next cycle. It then holds that position one more cycle without a write and expects a single pulse. Random rounds also issue writes at random raster positions, so writes fall on matches and on pending target advances. Every cycle is compared against a bench model of the requirements.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int TGT_W    = 10;
  localparam int HPOS_W   = 10;
  localparam int TGT_LSB  = 0;
  localparam int MODE_LSB = 12;
  localparam int HPOS_LSB = 16;
  localparam logic [31:0] CFG_MASK = 32'h03FF33FF;

  typedef enum logic [1:0] {
    HM_FRAME      = 2'd0,
    HM_EVERY_N    = 2'd1,
    HM_EVERY_LINE = 2'd2,
    HM_RSVD       = 2'd3
  } hirq_mode_e;
endpackage

// File: rtl/hirq_wrap.sv
module hirq_wrap #(
  parameter int W = 12
) (
  input  logic [W-1:0] sum_i,
  input  logic [W-1:0] half_i,
  output logic [W-1:0] wrapped_o
);
  localparam logic [W-1:0] ONE = 1;

  // Equivalent to repeatedly subtracting half while the value exceeds half.
  always_comb begin
    if (half_i != '0 && sum_i > half_i)
      wrapped_o = ((sum_i - ONE) % half_i) + ONE;
    else
      wrapped_o = sum_i;
  end
endmodule

// File: rtl/hirq_seq.sv
module hirq_seq
  import hirq_pkg::*;
#(
  parameter int RAS_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [31:0]       wdata_i,
  input  logic [RAS_W-1:0]  line_i,
  input  logic [RAS_W-1:0]  half_i,
  input  logic              fire_i,
  output logic              armed_o,
  output logic [TGT_W-1:0]  tgt_o,
  output logic [HPOS_W-1:0] hpos_o
);
  localparam int SUM_W = RAS_W + 1;
  localparam int NSUM  = 2;   // 0: start target on write, 1: advance after a pulse

  hirq_mode_e       wmode;
  logic [TGT_W-1:0] wfield;
  logic [TGT_W-1:0] wstep;
  logic [TGT_W-1:0] step_q;
  logic [TGT_W-1:0] tgt_q;
  logic             rep_q;
  logic             armed_q;
  logic [HPOS_W-1:0] hpos_q;
  logic [SUM_W-1:0] sum   [NSUM];
  logic [SUM_W-1:0] wrapd [NSUM];
  logic [SUM_W-1:0] half_ext;

  always_comb begin
    wmode    = hirq_mode_e'(wdata_i[MODE_LSB +: 2]);
    wfield   = wdata_i[TGT_LSB +: TGT_W];
    wstep    = (wmode == HM_EVERY_LINE) ? TGT_W'(1) : wfield;
    half_ext = SUM_W'(half_i);
    sum[0]   = SUM_W'(line_i >> 1) + SUM_W'(wstep);
    sum[1]   = SUM_W'(tgt_q) + SUM_W'(step_q);
  end

  for (genvar g = 0; g < NSUM; g++) begin : g_wrap
    hirq_wrap #(.W(SUM_W)) u_wrap (
      .sum_i     (sum[g]),
      .half_i    (half_ext),
      .wrapped_o (wrapd[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      tgt_q   <= '0;
      step_q  <= '0;
      rep_q   <= 1'b0;
      hpos_q  <= '0;
    end else if (wr_i) begin
      armed_q <= 1'b1;
      hpos_q  <= wdata_i[HPOS_LSB +: HPOS_W];
      case (wmode)
        HM_EVERY_N, HM_EVERY_LINE: begin
          step_q <= wstep;
          tgt_q  <= wrapd[0][TGT_W-1:0];
          rep_q  <= 1'b1;
        end
        default: begin
          step_q <= '0;
          tgt_q  <= wfield;
          rep_q  <= 1'b0;
        end
      endcase
    end else if (fire_i && rep_q) begin
      tgt_q <= wrapd[1][TGT_W-1:0];
    end
  end

  assign armed_o = armed_q;
  assign tgt_o   = tgt_q;
  assign hpos_o  = hpos_q;
endmodule

// File: rtl/hirq_match.sv
module hirq_match
  import hirq_pkg::*;
#(
  parameter int RAS_W = 11,
  parameter int DOT_W = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              armed_i,
  input  logic [TGT_W-1:0]  tgt_i,
  input  logic [HPOS_W-1:0] hpos_i,
  input  logic              wr_i,
  input  logic [RAS_W-1:0]  line_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              odd_i,
  input  logic              ilace_i,
  input  logic [RAS_W-1:0]  total_i,
  input  logic [DOT_W-1:0]  line_len_i,
  output logic              fire_o,
  output logic              irq_o
);
  localparam int CMP_W = (RAS_W > TGT_W + 1) ? RAS_W : TGT_W + 1;
  localparam logic [DOT_W-1:0] DONE = 1;

  logic [CMP_W-1:0] map_line;
  logic [DOT_W-1:0] hdots;
  logic [DOT_W-1:0] last_dot;
  logic [DOT_W-1:0] fire_dot;
  logic             hit;
  logic             hit_q;
  logic             irq_q;

  always_comb begin
    map_line = CMP_W'({tgt_i, ilace_i & odd_i});
    hdots    = DOT_W'({hpos_i, 1'b0});
    last_dot = line_len_i - DONE;
    fire_dot = (hdots > last_dot) ? last_dot : hdots;
    hit      = armed_i && !wr_i && (line_i < total_i) &&
               (CMP_W'(line_i) == map_line) && (dot_i == fire_dot);
    fire_o   = hit && !hit_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      hit_q <= hit;
      irq_q <= fire_o;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/hpos_raster_irq.sv
module hpos_raster_irq
  import hirq_pkg::*;
#(
  parameter int RAS_W = 11,
  parameter int DOT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [RAS_W-1:0] line_num,
  input  logic [DOT_W-1:0] dot_pos,
  input  logic             odd_field,
  input  logic             interlaced,
  input  logic [RAS_W-1:0] total_lines,
  input  logic [DOT_W-1:0] line_len,
  input  logic             cfg_wr,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_q,
  output logic             irq
);
  logic [31:0]       wmasked;
  logic [31:0]       cfg_r;
  logic [RAS_W-1:0]  half;
  logic              armed;
  logic [TGT_W-1:0]  tgt;
  logic [HPOS_W-1:0] hpos;
  logic              fire;

  assign wmasked = cfg_wdata & CFG_MASK;
  assign half    = total_lines >> 1;

  always_ff @(posedge clk) begin
    if (rst)         cfg_r <= '0;
    else if (cfg_wr) cfg_r <= wmasked;
  end
  assign cfg_q = cfg_r;

  hirq_seq #(.RAS_W(RAS_W)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (cfg_wr),
    .wdata_i (wmasked),
    .line_i  (line_num),
    .half_i  (half),
    .fire_i  (fire),
    .armed_o (armed),
    .tgt_o   (tgt),
    .hpos_o  (hpos)
  );

  hirq_match #(.RAS_W(RAS_W), .DOT_W(DOT_W)) u_match (
    .clk        (clk),
    .rst        (rst),
    .armed_i    (armed),
    .tgt_i      (tgt),
    .hpos_i     (hpos),
    .wr_i       (cfg_wr),
    .line_i     (line_num),
    .dot_i      (dot_pos),
    .odd_i      (odd_field),
    .ilace_i    (interlaced),
    .total_i    (total_lines),
    .line_len_i (line_len),
    .fire_o     (fire),
    .irq_o      (irq)
  );
endmodule

// File: rtl/hpos_raster_irq_chk.sv
module hpos_raster_irq_chk #(
  parameter int RAS_W = 11,
  parameter int DOT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic [RAS_W-1:0] line_num,
  input logic [DOT_W-1:0] dot_pos,
  input logic             odd_field,
  input logic             interlaced,
  input logic [RAS_W-1:0] total_lines,
  input logic             cfg_wr,
  input logic [31:0]      cfg_wdata,
  input logic [31:0]      cfg_q,
  input logic             irq
);
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  assert_write_quiet_R11: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> !irq);

  assert_cfg_mask_R2: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> (cfg_q == ($past(cfg_wdata) & 32'h03FF33FF)));

  assert_line_range_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(line_num) < $past(total_lines)));

  assert_field_parity_R5: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(line_num[0]) == ($past(interlaced) & $past(odd_field))));
endmodule

bind hpos_raster_irq hpos_raster_irq_chk #(.RAS_W(RAS_W), .DOT_W(DOT_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .line_num    (line_num),
  .dot_pos     (dot_pos),
  .odd_field   (odd_field),
  .interlaced  (interlaced),
  .total_lines (total_lines),
  .cfg_wr      (cfg_wr),
  .cfg_wdata   (cfg_wdata),
  .cfg_q       (cfg_q),
  .irq         (irq)
);

// File: tb/hpos_raster_irq_test.sv
`timescale 1ns/1ps
module hpos_raster_irq_test;
  localparam int RAS_W = 11;
  localparam int DOT_W = 11;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [RAS_W-1:0] line_num = '0;
  logic [DOT_W-1:0] dot_pos = '0;
  logic             odd_field = 1'b0;
  logic             interlaced = 1'b1;
  logic [RAS_W-1:0] total_lines = 11'd21;
  logic [DOT_W-1:0] line_len = 11'd16;
  logic             cfg_wr = 1'b0;
  logic [31:0]      cfg_wdata = '0;
  logic [31:0]      cfg_q;
  logic             irq;

  always #2 clk = ~clk;

  hpos_raster_irq #(.RAS_W(RAS_W), .DOT_W(DOT_W)) uut (.*);

  int n_chk = 0, n_bad = 0, pulses = 0;
  int last_line = -1, last_dot = -1;
  bit finished = 0;

  // bench model state
  bit m_arm = 0, m_rep = 0, m_hitq = 0;
  int m_tgt = 0, m_step = 0, m_h = 0;

  function automatic int wrapf(int s, int half);
    if (half != 0 && s > half) return ((s - 1) % half) + 1;
    return s;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, bit wr, logic [31:0] data, int ln, int dt);
    int half, lastd, fd, fld;
    bit hit, exp_irq;
    @(negedge clk);
    cfg_wr = wr; cfg_wdata = data;
    line_num = RAS_W'(ln); dot_pos = DOT_W'(dt);
    half  = int'(total_lines) / 2;
    lastd = int'(line_len) - 1;
    fd    = (2 * m_h > lastd) ? lastd : 2 * m_h;
    fld   = (interlaced && odd_field) ? 1 : 0;
    hit   = m_arm && !wr && ln < int'(total_lines) &&
            ln == 2 * m_tgt + fld && dt == fd;
    exp_irq = hit && !m_hitq;
    @(posedge clk); #1;
    chk(tag, int'(irq), int'(exp_irq));
    if (irq) begin pulses++; last_line = ln; last_dot = dt; end
    m_hitq = hit;
    if (wr) begin
      int md, fv;
      md = int'(data[13:12]); fv = int'(data[9:0]);
      m_arm = 1; m_h = int'(data[25:16]);
      if (md == 1 || md == 2) begin
        m_step = (md == 2) ? 1 : fv;
        m_tgt  = wrapf(ln / 2 + m_step, half) & 1023;
        m_rep  = 1;
      end else begin
        m_step = 0; m_tgt = fv; m_rep = 0;
      end
    end else if (exp_irq && m_rep) begin
      m_tgt = wrapf(m_tgt + m_step, half) & 1023;
    end
  endtask

  task automatic scan(string tag, int from_line);
    for (int l = from_line; l < int'(total_lines); l++)
      for (int d = 0; d < int'(line_len); d++)
        step(tag, 1'b0, 32'h0, l, d);
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #0;
    chk("R1 irq", int'(irq), 0);
    chk("R1 cfg", int'(cfg_q), 0);

    // R1: unconfigured, even at line 0 dot 0
    pulses = 0; scan("R1", 0); chk("R1 count", pulses, 0);

    // R2: masking, mode 3 target 1023 never reaches the raster (R5)
    step("R2", 1'b1, 32'hFFFF_FFFF, 0, 0);
    chk("R2", int'(cfg_q), 32'h03FF33FF);
    pulses = 0; scan("R5", 0); chk("R5 far target", pulses, 0);

    // R6/R3: mode 0 target 3, dot field 2 -> line 6 dot 4
    step("R6", 1'b1, 32'h0002_0003, 0, 0);
    pulses = 0; scan("R6", 1); chk("R6 count", pulses, 1);
    chk("R3 line", last_line, 6); chk("R3 dot", last_dot, 4);
    odd_field = 1; pulses = 0; scan("R5", 0); chk("R5 odd count", pulses, 1);
    chk("R5 odd line", last_line, 7);
    interlaced = 0; pulses = 0; scan("R5", 0); chk("R5 progressive line", last_line, 6);
    interlaced = 1;
    // R6: mode 3 acts like mode 0
    odd_field = 0;
    step("R6", 1'b1, 32'h0002_3003, 0, 0);
    pulses = 0; scan("R6", 0); scan("R6", 0); chk("R6 mode3 count", pulses, 2);

    // R5: target 10 maps to 21 in odd field, total 21 -> silent
    odd_field = 1;
    step("R5", 1'b1, 32'h0000_000A, 0, 0);
    pulses = 0; scan("R5", 0); chk("R5 beyond total", pulses, 0);
    odd_field = 0; pulses = 0; scan("R5", 0); chk("R5 line 20", pulses, 1);

    // R4: dot field 100 clamps to dot 15
    step("R4", 1'b1, 32'h0064_0002, 0, 0);
    pulses = 0; scan("R4", 0); chk("R4 dot", last_dot, 15); chk("R4 count", pulses, 1);

    // R7: mode 1 N=3 written at line 9 -> 4+3=7 (line 14), then 10 (line 20)
    step("R7", 1'b1, 32'h0000_1003, 9, 0);
    pulses = 0; scan("R7", 10); chk("R7 count", pulses, 2);

    // R8: N=3 from line 0: 3,6,9 then wrap 12->2,5,8
    step("R8", 1'b1, 32'h0000_1003, 0, 0);
    pulses = 0; scan("R8", 1); chk("R8 first frame", pulses, 3);
    pulses = 0; scan("R8", 0); chk("R8 wrapped frame", pulses, 3);
    chk("R8 last line", last_line, 16);

    // R9: mode 2 ignores line field, fires on lines 2..20
    step("R9", 1'b1, 32'h0000_2007, 0, 0);
    pulses = 0; scan("R9", 1); chk("R9 count", pulses, 10);

    // R11 and R10: write coinciding with a match, then held position
    step("R11", 1'b1, 32'h0002_0003, 0, 0);
    step("R11", 1'b1, 32'h0002_0003, 6, 4);
    chk("R11 quiet", int'(irq), 0);
    step("R10", 1'b0, 32'h0, 6, 4);
    chk("R10 pulse", int'(irq), 1);
    step("R10", 1'b0, 32'h0, 6, 4);
    chk("R10 single", int'(irq), 0);
    step("R10", 1'b0, 32'h0, 6, 5);

    // random rounds
    void'($urandom(32'd1234));
    for (int r = 0; r < 40; r++) begin
      int wl;
      total_lines = RAS_W'($urandom_range(9, 41));
      line_len    = DOT_W'($urandom_range(4, 20));
      interlaced  = 1'($urandom_range(0, 1));
      odd_field   = 1'($urandom_range(0, 1));
      wl = $urandom_range(0, int'(total_lines) - 1);
      step("R8", 1'b1,
           {6'd0, 10'($urandom_range(0, 15)), 2'd0, 2'($urandom_range(0, 3)),
            2'd0, 10'($urandom_range(0, int'(total_lines) / 2 + 2))}, wl, 0);
      for (int f = 0; f < 2; f++) begin
        scan("R8", 0);
        if (interlaced) odd_field = ~odd_field;
      end
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule